// File: doc/BRIEF.md
# Sensor Minimum/Maximum Tracking Registers

This block keeps a running record of the lowest and highest result seen for each on-chip sensor: die temperature, core supply and auxiliary supply. Each time the measurement path writes a result into the status registers, it raises a one-cycle strobe with a channel identifier and a 16-bit code. When the channel is one of the three internal sensors, the block compares the code against that sensor's stored extremes and replaces whichever one it beats.

The stored values start from inverted extremes after reset: each maximum is 0000h and each minimum is FFFFh. The first real sample for a sensor therefore always becomes both its maximum and its minimum. Software reads the six registers through a registered read port that decodes an eight-address window starting at 20h. Results from external channels pass by without any effect.

Top module: `sensor_minmax_track`

## Requirements
- R1: After reset, reads of 20h, 21h and 22h return 0000h, and reads of 24h, 25h and 26h return FFFFh.
- R2: The window maps the maximum of temperature, core supply and auxiliary supply to 20h, 21h and 22h, and their minimum to 24h, 25h and 26h. A read is issued with rd_en high and its result appears on rd_data after the next rising clock edge. rd_data holds its value while rd_en is low.
- R3: A sample for a sensor replaces that sensor's maximum only when it is strictly greater, compared as an unsigned number. An equal sample leaves the maximum unchanged.
- R4: A sample for a sensor replaces that sensor's minimum only when it is strictly less, compared as an unsigned number. An equal sample leaves the minimum unchanged.
- R5: Stored values change only in a cycle in which meas_valid is high.
- R6: Channel identifiers 0 (temperature), 1 (core supply) and 2 (auxiliary supply) are tracked. Any other identifier (3 to 31) causes no update.
- R7: The minimum and the maximum of a sensor update at the same clock edge. After that edge, the stored maximum is at least the sample and the stored minimum is at most the sample.
- R8: A read issued in the same cycle as an update returns the value from before the update.
- R9: Addresses 23h and 27h, and any address outside 20h to 27h, read as 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| meas_valid | input | 1 | Strobe marking a result written to the status registers |
| meas_chan | input | 5 | Channel identifier of the result |
| meas_data | input | 16 | Result code |
| rd_en | input | 1 | Read request |
| rd_addr | input | 8 | Read address |
| rd_data | output | 16 | Registered read data |

## Verification
The assertions assume that meas_chan and meas_data carry known values whenever meas_valid is high. They also assume that no strobe arrives while reset is held, because the monotonic checks compare each stored value with its value one cycle earlier. The stimulus drives every input on the falling edge and holds the strobe for exactly one cycle. It raises meas_valid only after the internal reset has been released for several cycles. When a reset is applied in the middle of a run, the strobe is low.

// File: rtl/minmax_pkg.sv
package minmax_pkg;
  localparam int unsigned SENSE_W  = 16;
  localparam int unsigned CHAN_W   = 5;
  localparam int unsigned NUM_SENS = 3;
  localparam int unsigned ADDR_W   = 8;
  localparam logic [ADDR_W-1:0] WIN_BASE = 8'h20;

  typedef logic [SENSE_W-1:0] sample_t;
endpackage

// File: rtl/minmax_rst_sync.sv
module minmax_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/minmax_cell.sv
module minmax_cell #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [W-1:0] sample,
  output logic [W-1:0] max_q,
  output logic [W-1:0] min_q
);
  logic [W-1:0] max_d;
  logic [W-1:0] min_d;
  logic         max_en;
  logic         min_en;

  always_comb begin
    max_en = upd && (sample > max_q);
    min_en = upd && (sample < min_q);
    max_d  = max_en ? sample : max_q;
    min_d  = min_en ? sample : min_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q <= '0;
      min_q <= '1;
    end else begin
      max_q <= max_d;
      min_q <= min_d;
    end
  end
endmodule

// File: rtl/minmax_readmux.sv
module minmax_readmux #(
  parameter int unsigned W      = 16,
  parameter int unsigned N      = 3,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h20
) (
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [N-1:0][W-1:0] max_all,
  input  logic [N-1:0][W-1:0] min_all,
  output logic [W-1:0]        word
);
  localparam int unsigned IDX_W = 2;

  logic             in_win;
  logic             is_min;
  logic [IDX_W-1:0] idx;

  always_comb begin
    in_win = (rd_addr[ADDR_W-1:3] == BASE[ADDR_W-1:3]);
    is_min = rd_addr[2];
    idx    = rd_addr[1:0];
    word   = '0;
    for (int s = 0; s < int'(N); s++) begin
      if (in_win && idx == IDX_W'(s)) word = is_min ? min_all[s] : max_all[s];
    end
  end
endmodule

// File: rtl/sensor_minmax_track.sv
module sensor_minmax_track
  import minmax_pkg::*;
#(
  parameter int unsigned W      = SENSE_W,
  parameter int unsigned CW     = CHAN_W,
  parameter int unsigned N      = NUM_SENS,
  parameter int unsigned AW     = ADDR_W,
  parameter logic [AW-1:0] BASE = WIN_BASE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          meas_valid,
  input  logic [CW-1:0] meas_chan,
  input  logic [W-1:0]  meas_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic                rst_n_sync;
  logic [N-1:0][W-1:0] max_all;
  logic [N-1:0][W-1:0] min_all;
  logic [W-1:0]        rd_word;
  logic [W-1:0]        rd_data_d;

  minmax_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  for (genvar g = 0; g < int'(N); g++) begin : g_sens
    logic hit;
    assign hit = meas_valid && (meas_chan == CW'(g));
    minmax_cell #(.W(W)) u_cell (
      .clk(clk), .rst_n(rst_n_sync), .upd(hit), .sample(meas_data),
      .max_q(max_all[g]), .min_q(min_all[g])
    );
  end

  minmax_readmux #(.W(W), .N(N), .ADDR_W(AW), .BASE(BASE)) u_mux (
    .rd_addr(rd_addr), .max_all(max_all), .min_all(min_all), .word(rd_word)
  );

  always_comb begin
    rd_data_d = rd_en ? rd_word : rd_data;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) rd_data <= '0;
    else             rd_data <= rd_data_d;
  end
endmodule

// File: rtl/sensor_minmax_track_chk.sv
module sensor_minmax_track_chk #(
  parameter int unsigned W  = 16,
  parameter int unsigned CW = 5,
  parameter int unsigned N  = 3
) (
  input logic                clk,
  input logic                rst_n_sync,
  input logic                meas_valid,
  input logic [CW-1:0]       meas_chan,
  input logic [W-1:0]        meas_data,
  input logic [N-1:0][W-1:0] max_all,
  input logic [N-1:0][W-1:0] min_all
);
  for (genvar g = 0; g < int'(N); g++) begin : g_chk
    // R3
    p_max_nodec_r3: assert property (@(posedge clk) disable iff (!rst_n_sync)
      max_all[g] >= $past(max_all[g]));
    // R4
    p_min_noinc_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
      min_all[g] <= $past(min_all[g]));
    // R5
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
      !meas_valid |=> ($stable(max_all[g]) && $stable(min_all[g])));
    // R6
    p_ext_hold_r6: assert property (@(posedge clk) disable iff (!rst_n_sync)
      (meas_valid && meas_chan >= CW'(N)) |=> ($stable(max_all[g]) && $stable(min_all[g])));
    // R7
    p_sample_bound_r7: assert property (@(posedge clk) disable iff (!rst_n_sync)
      (meas_valid && meas_chan == CW'(g)) |=>
        (max_all[g] >= $past(meas_data) && min_all[g] <= $past(meas_data)));
  end
endmodule

bind sensor_minmax_track sensor_minmax_track_chk #(.W(W), .CW(CW), .N(N)) u_chk (
  .clk(clk), .rst_n_sync(rst_n_sync), .meas_valid(meas_valid),
  .meas_chan(meas_chan), .meas_data(meas_data),
  .max_all(max_all), .min_all(min_all)
);

// File: tb/test_sensor_minmax_track.sv
`timescale 1ns/1ps
module test_sensor_minmax_track;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        meas_valid;
  logic [4:0]  meas_chan;
  logic [15:0] meas_data;
  logic        rd_en;
  logic [7:0]  rd_addr;
  logic [15:0] rd_data;
  int          n_run = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  sensor_minmax_track i_sensor_minmax_track (
    .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_chan(meas_chan),
    .meas_data(meas_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // {chan, data, read address, expected}
  localparam int NV = 13;
  localparam logic [44:0] VEC [NV] = '{
    {5'd0,  16'h1234, 8'h20, 16'h1234}, // R3 first sample
    {5'd0,  16'h1000, 8'h24, 16'h1000}, // R4
    {5'd0,  16'h2000, 8'h20, 16'h2000}, // R3
    {5'd0,  16'h1500, 8'h24, 16'h1000}, // R4 no change
    {5'd1,  16'h8000, 8'h21, 16'h8000}, // R2 core max
    {5'd1,  16'h8000, 8'h25, 16'h8000}, // R7 min same edge
    {5'd2,  16'h0000, 8'h26, 16'h0000}, // R4 aux min
    {5'd2,  16'hFFFF, 8'h22, 16'hFFFF}, // R3 aux max
    {5'd3,  16'h9999, 8'h20, 16'h2000}, // R6 external
    {5'd16, 16'h0001, 8'h24, 16'h1000}, // R6 external
    {5'd0,  16'h2000, 8'h20, 16'h2000}, // R3 equal
    {5'd1,  16'h0005, 8'h27, 16'h0000}, // R9 unused
    {5'd1,  16'h0005, 8'h23, 16'h0000}  // R9 unused
  };

  task automatic check(input string req, input logic [15:0] exp);
    n_run++;
    if (rd_data !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
    end
  endtask

  task automatic do_read(input logic [7:0] a, input logic [15:0] exp, input string req);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0;
    check(req, exp);
  endtask

  task automatic do_write(input logic [4:0] c, input logic [15:0] d);
    @(negedge clk); meas_valid = 1'b1; meas_chan = c; meas_data = d;
    @(negedge clk); meas_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog: run hung");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    meas_valid = 1'b0; meas_chan = '0; meas_data = '0; rd_en = 1'b0; rd_addr = '0;
    do_reset();
    // R1 reset state
    for (int a = 0; a < 3; a++) do_read(8'h20 + 8'(a), 16'h0000, "R1");
    for (int a = 0; a < 3; a++) do_read(8'h24 + 8'(a), 16'hFFFF, "R1");

    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i][44:40], VEC[i][39:24]);
      do_read(VEC[i][23:16], VEC[i][15:0], $sformatf("R2/vec%0d", i));
    end

    // R5: data on bus without strobe
    @(negedge clk); meas_valid = 1'b0; meas_chan = 5'd0; meas_data = 16'hFFFF;
    @(negedge clk); meas_data = 16'h0000;
    do_read(8'h20, 16'h2000, "R5");
    do_read(8'h24, 16'h1000, "R5");

    // R2 hold while rd_en low
    repeat (3) @(negedge clk);
    check("R2 hold", 16'h1000);

    // R8: read in the update cycle returns the old value
    @(negedge clk); meas_valid = 1'b1; meas_chan = 5'd0; meas_data = 16'hF000;
    rd_en = 1'b1; rd_addr = 8'h20;
    @(negedge clk); meas_valid = 1'b0; rd_en = 1'b0;
    check("R8", 16'h2000);
    do_read(8'h20, 16'hF000, "R8 after");

    // R9 outside window
    do_read(8'h30, 16'h0000, "R9");
    do_read(8'h1F, 16'h0000, "R9");

    // R1 reset mid-run
    do_reset();
    do_read(8'h20, 16'h0000, "R1 again");
    do_read(8'h25, 16'hFFFF, "R1 again");
    do_read(8'h22, 16'h0000, "R1 again");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule